// File: doc/BRIEF.md
# Packed Byte Sum-of-Absolute-Differences Unit

This block compares two wide operands byte by byte. Each operand is treated as a row of unsigned 8-bit values. For each byte position the block takes the absolute difference. It then adds the differences in groups of eight adjacent bytes. Each group total is an unsigned value of at most 2040. It is written zero-extended into the low 16 bits of the matching 64-bit lane of the result, and the other 48 bits of that lane are cleared. Motion estimation and similarity search kernels use this kind of unit as a building block.

A two-bit length select sets how much of the 512-bit datapath is active: one, two, four or eight lanes. A separate fill select governs the bits above the active length. Those bits are either cleared or taken from a prior destination word that arrives with the operands. The operands, the prior word and both selects are captured together when a valid/ready handshake is accepted. The result appears two cycles later on an output valid/ready handshake. The whole pipeline holds while the consumer is not ready.

Top module: `sad_unit`

## Requirements
- R1: For every active lane l, outData[64*l+15 : 64*l] equals the sum of |a - b| over bytes 8*l to 8*l+7 of srcA and srcB, both read as unsigned; this value never exceeds 2040.
- R2: In every active lane, bits 16 to 63 of that lane are zero.
- R3: The mode input sets the number of active lanes: 2'd0 gives 1 lane (64 bits), 2'd1 gives 2 lanes (128), 2'd2 gives 4 lanes (256), 2'd3 gives 8 lanes (512). Lane 0 is always active.
- R4: With keepUpper = 0, every output bit at or above the active length is zero.
- R5: With keepUpper = 1, every output bit at or above the active length equals the same bit of the oldDest value captured with the operands.
- R6: An operation is accepted on a rising edge where inValid and inReady are both 1. If the pipeline does not stall, its result is shown with outValid = 1 after the second following rising edge. inReady is 1 exactly when outValid is 0 or outReady is 1.
- R7: While outValid = 1 and outReady = 0, outValid stays 1 and outData does not change on the next edge.
- R8: srcA, srcB, oldDest, mode and keepUpper are used only as sampled at the accepting edge. Later changes on those inputs do not alter that operation's result.
- R9: After reset outValid is 0, outData is all zero and inReady is 1.
- R10: Results leave in acceptance order, each exactly once, and at most two operations are in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operation offered |
| inReady | output | 1 | Operation can be taken this cycle |
| srcA | input | 512 | First byte operand |
| srcB | input | 512 | Second byte operand |
| oldDest | input | 512 | Prior destination value used by the keep policy |
| mode | input | 2 | Active length select (R3 encoding) |
| keepUpper | input | 1 | 1 keeps bits above the active length, 0 clears them |
| outValid | output | 1 | Result present |
| outReady | input | 1 | Consumer takes the result |
| outData | output | 512 | Packed result |

## Verification
One case makes two functions fall on the same edge: a finished result leaves the output stage while a new operation enters the first stage. The bench provokes it by holding outReady low with two operations in flight and a third one waiting on the inputs, then raising outReady. Across the stall it checks that the held output stays frozen and that inReady is low. After the release it checks that the three results come out one per cycle in order, each matching the selects sampled at its own acceptance even though the input pins were changed in between.

// File: rtl/sad_pkg.sv
package sad_pkg;

  // Active vector length select, encoded as log2 of the lane count.
  typedef enum logic [1:0] {
    VL_64  = 2'd0,
    VL_128 = 2'd1,
    VL_256 = 2'd2,
    VL_512 = 2'd3
  } vecLenT;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic s1Load;  // capture operands and byte differences
    logic s2Load;  // capture lane sums and merged output
  } pipeStrobeT;

endpackage

// File: rtl/sad_ctrl.sv
module sad_ctrl
  import sad_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic       outReady,
  output logic       inReady,
  output logic       outValid,
  output pipeStrobeT strobe
);

  logic s1Valid;
  logic s2Valid;
  logic pipeEn;

  // One enable moves both stages; a held output freezes everything.
  assign pipeEn   = !s2Valid || outReady;
  assign inReady  = pipeEn;
  assign outValid = s2Valid;

  always_comb begin
    strobe        = '0;
    strobe.s1Load = inValid && pipeEn;
    strobe.s2Load = s1Valid && pipeEn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1Valid <= 1'b0;
      s2Valid <= 1'b0;
    end else if (pipeEn) begin
      s1Valid <= inValid;
      s2Valid <= s1Valid;
    end
  end

endmodule

// File: rtl/sad_datapath.sv
module sad_datapath
  import sad_pkg::*;
#(
  parameter int DATA_W = 512,
  parameter int BYTE_W = 8,
  parameter int LANE_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  pipeStrobeT        strobe,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [DATA_W-1:0] oldDest,
  input  vecLenT            mode,
  input  logic              keepUpper,
  output logic [DATA_W-1:0] result
);

  localparam int NUM_BYTES = DATA_W / BYTE_W;
  localparam int NUM_LANES = DATA_W / LANE_W;
  localparam int BPL       = LANE_W / BYTE_W;
  localparam int MAX_SUM   = BPL * ((1 << BYTE_W) - 1);
  localparam int SUM_W     = $clog2(MAX_SUM + 1);
  localparam int NODES     = 2 * BPL - 1;

  // Stage 1: byte differences plus captured side information.
  logic [NUM_BYTES-1:0][BYTE_W-1:0] diffD;
  logic [NUM_BYTES-1:0][BYTE_W-1:0] diffQ;
  logic [DATA_W-1:0]                oldQ;
  vecLenT                           modeQ;
  logic                             keepQ;

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
    logic [BYTE_W-1:0] byteA;
    logic [BYTE_W-1:0] byteB;
    assign byteA    = srcA[i*BYTE_W +: BYTE_W];
    assign byteB    = srcB[i*BYTE_W +: BYTE_W];
    assign diffD[i] = (byteA >= byteB) ? (byteA - byteB) : (byteB - byteA);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      diffQ <= '0;
      oldQ  <= '0;
      modeQ <= VL_64;
      keepQ <= 1'b0;
    end else if (strobe.s1Load) begin
      diffQ <= diffD;
      oldQ  <= oldDest;
      modeQ <= mode;
      keepQ <= keepUpper;
    end
  end

  // Stage 2: per-lane adder tree and length/fill merge.
  logic [DATA_W-1:0] resultD;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic [SUM_W-1:0] node [NODES];
    logic             laneOn;

    for (genvar j = 0; j < BPL; j++) begin : g_leaf
      assign node[BPL-1+j] = SUM_W'(diffQ[l*BPL+j]);
    end
    for (genvar k = 0; k < BPL - 1; k++) begin : g_node
      assign node[k] = node[2*k+1] + node[2*k+2];
    end

    // Lane l is active when l < 2**mode.
    assign laneOn = (32'(l) >> modeQ) == 32'd0;

    assign resultD[l*LANE_W +: LANE_W] =
      laneOn ? {{(LANE_W-SUM_W){1'b0}}, node[0]}
             : (keepQ ? oldQ[l*LANE_W +: LANE_W] : {LANE_W{1'b0}});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
    end else if (strobe.s2Load) begin
      result <= resultD;
    end
  end

endmodule

// File: rtl/sad_unit.sv
module sad_unit
  import sad_pkg::*;
#(
  parameter int DATA_W = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [DATA_W-1:0] oldDest,
  input  logic [1:0]        mode,
  input  logic              keepUpper,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData
);

  pipeStrobeT strobe;

  sad_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .strobe   (strobe)
  );

  sad_datapath #(
    .DATA_W (DATA_W)
  ) dp_i (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .srcA      (srcA),
    .srcB      (srcB),
    .oldDest   (oldDest),
    .mode      (vecLenT'(mode)),
    .keepUpper (keepUpper),
    .result    (outData)
  );

endmodule

// File: rtl/sad_unit_chk.sv
module sad_unit_chk #(
  parameter int DATA_W = 512
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic              inReady,
  input logic              outValid,
  input logic              outReady,
  input logic [DATA_W-1:0] outData
);

  logic [1:0] cyc;
  logic [2:0] inFlight;
  logic       accept;
  logic       emit;

  assign accept = inValid && inReady;
  assign emit   = outValid && outReady;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc      <= '0;
      inFlight <= '0;
    end else begin
      if (cyc != 2'd3) cyc <= cyc + 2'd1;
      inFlight <= inFlight + {2'b0, accept} - {2'b0, emit};
    end
  end

  assert_sum_range_R1: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outData[15:0] <= 16'd2040));

  assert_lane0_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outData[63:16] == 48'd0));

  assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 2'd2 && $past(accept, 2) && $past(inReady)) |-> outValid);

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  assert_idle_after_reset_R9: assert property (@(posedge clk) disable iff (rst)
    (cyc == 2'd0) |-> (!outValid && inReady));

  assert_flight_bound_R10: assert property (@(posedge clk) disable iff (rst)
    (inFlight <= 3'd2) && (!outValid || inFlight != 3'd0));

endmodule

bind sad_unit sad_unit_chk #(.DATA_W(DATA_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .inReady  (inReady),
  .outValid (outValid),
  .outReady (outReady),
  .outData  (outData)
);

// File: tb/sad_unit_tb.sv
`timescale 1ns/1ps
module sad_unit_tb_top;

  localparam int W = 512;

  typedef struct packed {
    logic [31:0] seedA;
    logic [31:0] seedB;
    logic [31:0] seedOld;
    logic [1:0]  vl;
    logic        keep;
  } vecT;

  localparam int NVEC = 10;
  localparam vecT VECS [NVEC] = '{
    '{32'h0000_1234, 32'h0000_8765, 32'hDEAD_0001, 2'd0, 1'b0},
    '{32'h0000_1111, 32'h0000_2222, 32'hDEAD_0002, 2'd0, 1'b1},
    '{32'h00AB_CDEF, 32'h0012_3456, 32'hDEAD_0003, 2'd1, 1'b0},
    '{32'h0BAD_F00D, 32'h0C0F_FEE0, 32'hDEAD_0004, 2'd1, 1'b1},
    '{32'h1357_9BDF, 32'h2468_ACE0, 32'hDEAD_0005, 2'd2, 1'b0},
    '{32'h5555_AAAA, 32'hAAAA_5555, 32'hDEAD_0006, 2'd2, 1'b1},
    '{32'h7777_0000, 32'h0000_7777, 32'hDEAD_0007, 2'd3, 1'b0},
    '{32'h0F0F_F0F0, 32'hF0F0_0F0F, 32'hDEAD_0008, 2'd3, 1'b1},
    '{32'h0000_0042, 32'h0000_0042, 32'hDEAD_0009, 2'd3, 1'b0},
    '{32'h9999_0001, 32'h3333_0002, 32'hDEAD_000A, 2'd1, 1'b1}
  };

  logic         clk = 1'b0;
  logic         rst;
  logic         inValid;
  logic         inReady;
  logic [W-1:0] srcA;
  logic [W-1:0] srcB;
  logic [W-1:0] oldDest;
  logic [1:0]   mode;
  logic         keepUpper;
  logic         outValid;
  logic         outReady;
  logic [W-1:0] outData;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sad_unit #(.DATA_W(W)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .inReady   (inReady),
    .srcA      (srcA),
    .srcB      (srcB),
    .oldDest   (oldDest),
    .mode      (mode),
    .keepUpper (keepUpper),
    .outValid  (outValid),
    .outReady  (outReady),
    .outData   (outData)
  );

  function automatic logic [W-1:0] pat(input logic [31:0] seed);
    logic [31:0]  x;
    logic [W-1:0] r;
    x = seed;
    r = '0;
    for (int i = 0; i < W / 8; i++) begin
      x = x * 32'd1664525 + 32'd1013904223;
      r[i*8 +: 8] = x[31:24];
    end
    return r;
  endfunction

  // Reference built from R1..R5.
  function automatic logic [W-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic [W-1:0] o, input logic [1:0] m,
                                         input logic k);
    logic [W-1:0] r;
    int           lanes;
    int           s;
    int           da;
    int           db;
    r = '0;
    lanes = 1 << m;
    for (int l = 0; l < W / 64; l++) begin
      if (l < lanes) begin
        s = 0;
        for (int j = 0; j < 8; j++) begin
          da = int'(a[(l*8+j)*8 +: 8]);
          db = int'(b[(l*8+j)*8 +: 8]);
          s += (da > db) ? da - db : db - da;
        end
        r[l*64 +: 64] = 64'(s);
      end else begin
        r[l*64 +: 64] = k ? o[l*64 +: 64] : 64'd0;
      end
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [W-1:0] o, input logic [1:0] m, input logic k);
    srcA = a; srcB = b; oldDest = o; mode = m; keepUpper = k;
  endtask

  // Single operation on an idle pipe with outReady high.
  task automatic runOne(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [W-1:0] o, input logic [1:0] m, input logic k,
                        input string tag);
    logic [W-1:0] exp;
    exp = model(a, b, o, m, k);
    @(negedge clk);
    drive(a, b, o, m, k);
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    drive(~a, b, ~o, ~m, ~k);  // R8: pins change after acceptance
    check(outValid == 1'b0, "R6 not yet valid", W'(outValid), W'(0));
    @(negedge clk);
    check(outValid == 1'b1, "R6 valid after two edges", W'(outValid), W'(1));
    check(outData == exp, tag, outData, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] xa, xb, xo, ya, yb, yo, za, zb, zo, ex, ey, ez;
    rst = 1'b1; inValid = 1'b0; outReady = 1'b1;
    drive('0, '0, '0, 2'd0, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(outValid == 1'b0, "R9 outValid", W'(outValid), W'(0));
    check(outData == '0, "R9 outData", outData, '0);
    check(inReady == 1'b1, "R9 inReady", W'(inReady), W'(1));
    rst = 1'b0;

    // Table walk: R1 R2 R3 with R4 or R5 per entry.
    for (int v = 0; v < NVEC; v++) begin
      runOne(pat(VECS[v].seedA), pat(VECS[v].seedB), pat(VECS[v].seedOld),
             VECS[v].vl, VECS[v].keep,
             VECS[v].keep ? "R1 R2 R3 R5 table" : "R1 R2 R3 R4 table");
    end

    // R1 boundary: maximum difference in every lane, both orders.
    runOne({W{1'b1}}, '0, pat(32'h1), 2'd3, 1'b0, "R1 max sum 2040");
    check(outData[15:0] == 16'd2040, "R1 max lane0", W'(outData[15:0]), W'(2040));
    runOne('0, {W{1'b1}}, pat(32'h2), 2'd3, 1'b1, "R1 max sum swapped");
    // R3/R5: 64-bit length keeps everything above lane 0.
    runOne(pat(32'h3), pat(32'h4), {W{1'b1}}, 2'd0, 1'b1, "R3 R5 single lane keep");
    // R4: 256-bit length with all-ones old value must still clear upper half.
    runOne(pat(32'h5), pat(32'h6), {W{1'b1}}, 2'd2, 1'b0, "R3 R4 upper cleared");

    // Stall with emit and accept on the same edge (R7 R8 R10).
    xa = pat(32'h10); xb = pat(32'h11); xo = pat(32'h12);
    ya = pat(32'h20); yb = pat(32'h21); yo = pat(32'h22);
    za = pat(32'h30); zb = pat(32'h31); zo = pat(32'h32);
    ex = model(xa, xb, xo, 2'd3, 1'b0);
    ey = model(ya, yb, yo, 2'd1, 1'b1);
    ez = model(za, zb, zo, 2'd0, 1'b0);
    @(negedge clk);
    outReady = 1'b0;
    drive(xa, xb, xo, 2'd3, 1'b0);
    inValid = 1'b1;
    @(negedge clk);
    drive(ya, yb, yo, 2'd1, 1'b1);
    @(negedge clk);
    drive(za, zb, zo, 2'd0, 1'b0);
    check(inReady == 1'b0, "R6 inReady low when held", W'(inReady), W'(0));
    for (int h = 0; h < 3; h++) begin
      check(outValid == 1'b1 && outData == ex, "R7 held output", outData, ex);
      @(negedge clk);
    end
    outReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    drive(~za, zb, ~zo, 2'd3, 1'b1);
    check(outValid == 1'b1 && outData == ey, "R8 R10 second result", outData, ey);
    @(negedge clk);
    check(outValid == 1'b1 && outData == ez, "R8 R10 third result", outData, ez);
    @(negedge clk);
    check(outValid == 1'b0, "R10 no duplicate", W'(outValid), W'(0));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule